// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits behind a 32-bit register port and counts on a slow time base. The slow time base arrives as a one-cycle enable pulse, `slow_en`, that is synchronous to the register clock. Software loads a start value and picks an optional prescale ratio. It then starts the counter with a two-word key sequence. Once running, the counter counts upward. Software keeps it away from overflow by writing new values to the trigger register, and each such write reloads the counter. If the counter wraps past its all-ones value while running, the block drives a reset pulse of fixed length and records a sticky reset-source flag.

Four registers are posted writes into the slow domain: control, load, trigger and start/stop. A write to one of them takes effect only after a synchronisation delay counted in slow ticks. During that delay a per-register pending bit is set, and the register still reads its old effective value. Software polls the pending bits before it writes again or relies on the new value. The system configuration register is not posted. Its bit 0 drives an interface idle-gating enable output directly.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every readable register reads 0. The register byte offsets are control 0x00, load 0x04, trigger 0x08, start/stop 0x0C, pending 0x10, system configuration 0x14, counter 0x18 and reset status 0x1C. After reset `wdt_rst_o` and `idle_gate_o` are low and the counter is stopped.
- R2: A committed start/stop value of 0x0000BBBB followed by a committed 0x00004444 starts the counter. While running, the counter rises by one per step from the value it held, beginning with the value it held at start.
- R3: A committed 0x0000AAAA followed by a committed 0x00005555 stops the counter. While stopped, the counter value does not change except by a trigger reload.
- R4: A key sequence counts only if its second word is the very next committed start/stop value. Any other value committed in between discards the partial sequence, so the running state stays as it was.
- R5: The pending register (0x10) has bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for start/stop. The bit is set from the clock edge that accepts the write. It clears on the edge of the SYNC_TICKS-th following slow tick (2 by default), and the new value takes effect on that same edge. Until then the register reads its old value.
- R6: A write to a posted register while its pending bit is set is ignored.
- R7: When a trigger write commits, the counter reloads from the effective load value, and that step does not advance it. This happens only if the trigger value differs from the previously committed trigger value, which is 0 after reset. A trigger value equal to the previous one has no effect on the counter.
- R8: Control bit 5 enables the prescaler, and control bits 4:2 hold the ratio r. With the prescaler enabled, the running counter steps once every 2^r slow ticks. With it disabled, the counter steps on every slow tick.
- R9: When the running counter steps past the all-ones value, three things happen on the same edge. The counter reloads from the load value and keeps running, `wdt_rst_o` goes high for exactly RST_CYCLES clock cycles, and bit 0 of the reset status register (0x1C) becomes 1. That bit stays 1 until reset.
- R10: A write to the system configuration register takes effect on the next clock edge without any pending bit, and its bit 0 drives `idle_gate_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle pulse per slow time-base tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| idle_gate_o | output | 1 | Interface idle-gating enable |

## Verification
The bench builds the block with its defaults: a 32-bit counter, SYNC_TICKS of 2 and RST_CYCLES of 4. It drives `slow_en` by hand, one tick at a time, so every commit edge and counter step is known in advance. Because the counter is full width, the test reaches overflow by loading 0xFFFFFFFD through a trigger reload, which keeps the wrap and the reset pulse a few ticks away. A prescale ratio of 2 keeps the 4-tick stepping pattern short enough to check both between steps and on the step.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int DATA_W  = 32;
    localparam int RATIO_W = 3;
    localparam int NSLOT   = 4;

    typedef enum logic [2:0] {
        IDX_CTRL = 3'd0,
        IDX_LOAD = 3'd1,
        IDX_TRIG = 3'd2,
        IDX_KEY  = 3'd3,
        IDX_PEND = 3'd4,
        IDX_SYS  = 3'd5,
        IDX_CNT  = 3'd6,
        IDX_STAT = 3'd7
    } reg_idx_e;

    localparam logic [DATA_W-1:0] KEY_ON_A  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_ON_B  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_OFF_A = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_OFF_B = 32'h0000_5555;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARM_ON,
        KS_ARM_OFF
    } key_st_e;
endpackage

// File: rtl/kwdt_post.sv
module kwdt_post #(
    parameter int DW         = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          commit,
    output logic [DW-1:0] cdata
);
    localparam int CW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
    } post_t;

    post_t s_q, s_d;
    logic  last;

    always_comb begin
        s_d    = s_q;
        last   = (s_q.cnt == CW'(SYNC_TICKS - 1));
        commit = s_q.busy && slow_en && last;
        if (!s_q.busy) begin
            if (wr) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.data = wdata;
            end
        end else if (slow_en) begin
            if (last) s_d.busy = 1'b0;
            else      s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign cdata = s_q.data;
endmodule

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] word,
    output logic              run
);
    typedef struct packed {
        key_st_e st;
        logic    run;
    } key_t;

    key_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (commit) begin
            if (word == KEY_ON_A) begin
                s_d.st = KS_ARM_ON;
            end else if (word == KEY_OFF_A) begin
                s_d.st = KS_ARM_OFF;
            end else if (word == KEY_ON_B) begin
                if (s_q.st == KS_ARM_ON) s_d.run = 1'b1;
                s_d.st = KS_IDLE;
            end else if (word == KEY_OFF_B) begin
                if (s_q.st == KS_ARM_OFF) s_d.run = 1'b0;
                s_d.st = KS_IDLE;
            end else begin
                s_d.st = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: KS_IDLE, run: 1'b0};
        else        s_q <= s_d;
    end

    assign run = s_q.run;
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
    parameter int CNT_W      = 32,
    parameter int RATIO_W    = 3,
    parameter int RST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_en,
    input  logic               run,
    input  logic               pre_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               reload,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   count,
    output logic               rst_out,
    output logic               sticky
);
    localparam int PRE_W = (1 << RATIO_W) - 1;
    localparam int RW    = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic [RW-1:0]    pulse;
        logic             sticky;
    } cnt_t;

    cnt_t           s_q, s_d;
    logic [PRE_W:0] one_sh;
    logic [PRE_W-1:0] pre_lim;
    logic           due;

    always_comb begin
        s_d     = s_q;
        one_sh  = (PRE_W + 1)'(1) << ratio;
        pre_lim = PRE_W'(one_sh - 1'b1);
        due     = !pre_en || (s_q.pre == pre_lim);
        if (s_q.pulse != '0) s_d.pulse = s_q.pulse - 1'b1;
        if (reload) begin
            s_d.cnt = load_val;
            s_d.pre = '0;
        end else if (!run) begin
            s_d.pre = '0;
        end else if (slow_en) begin
            if (due) begin
                s_d.pre = '0;
                if (s_q.cnt == '1) begin
                    s_d.cnt    = load_val;
                    s_d.pulse  = RW'(RST_CYCLES);
                    s_d.sticky = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign rst_out = (s_q.pulse != '0);
    assign sticky  = s_q.sticky;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_o,
    output logic              idle_gate_o
);
    typedef struct packed {
        logic               pre_en;
        logic [RATIO_W-1:0] ratio;
        logic [DATA_W-1:0]  load;
        logic [DATA_W-1:0]  trig;
        logic [DATA_W-1:0]  key;
        logic               idle;
    } regs_t;

    regs_t             s_q, s_d;
    logic              addr_ok;
    reg_idx_e          idx;
    logic [7:0]        wr_sel;
    logic [NSLOT-1:0]  slot_busy;
    logic [NSLOT-1:0]  slot_commit;
    logic [DATA_W-1:0] slot_data [NSLOT];
    logic              reload;
    logic              run;
    logic [CNT_W-1:0]  count;
    logic              sticky;
    logic [DATA_W-1:0] pend_vec;
    logic [DATA_W-1:0] load_eff;
    logic              unused_bits;

    assign addr_ok = ((bus_addr >> 5) == '0);
    assign idx     = reg_idx_e'(bus_addr[4:2]);
    assign wr_sel  = (bus_wr && addr_ok) ? (8'd1 << idx) : 8'd0;

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            kwdt_post #(.DW(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_post (
                .clk    (clk),
                .rst_n  (rst_n),
                .slow_en(slow_en),
                .wr     (wr_sel[g]),
                .wdata  (bus_wdata),
                .busy   (slot_busy[g]),
                .commit (slot_commit[g]),
                .cdata  (slot_data[g])
            );
        end
    endgenerate

    always_comb begin
        s_d    = s_q;
        reload = 1'b0;
        if (slot_commit[IDX_CTRL]) begin
            s_d.pre_en = slot_data[IDX_CTRL][5];
            s_d.ratio  = slot_data[IDX_CTRL][4:2];
        end
        if (slot_commit[IDX_LOAD]) s_d.load = slot_data[IDX_LOAD];
        if (slot_commit[IDX_TRIG]) begin
            s_d.trig = slot_data[IDX_TRIG];
            reload   = (slot_data[IDX_TRIG] != s_q.trig);
        end
        if (slot_commit[IDX_KEY]) s_d.key = slot_data[IDX_KEY];
        if (wr_sel[IDX_SYS]) s_d.idle = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    kwdt_keyfsm u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(slot_commit[IDX_KEY]),
        .word  (slot_data[IDX_KEY]),
        .run   (run)
    );

    kwdt_count #(.CNT_W(CNT_W), .RATIO_W(RATIO_W), .RST_CYCLES(RST_CYCLES)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_en (slow_en),
        .run     (run),
        .pre_en  (s_q.pre_en),
        .ratio   (s_q.ratio),
        .reload  (reload),
        .load_val(CNT_W'(s_q.load)),
        .count   (count),
        .rst_out (wdt_rst_o),
        .sticky  (sticky)
    );

    assign pend_vec    = DATA_W'({slot_busy[IDX_KEY], slot_busy[IDX_TRIG],
                                  slot_busy[IDX_LOAD], 1'b0, slot_busy[IDX_CTRL]});
    assign load_eff    = s_q.load;
    assign idle_gate_o = s_q.idle;

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            case (idx)
                IDX_CTRL: bus_rdata = DATA_W'({s_q.pre_en, s_q.ratio, 2'b00});
                IDX_LOAD: bus_rdata = s_q.load;
                IDX_TRIG: bus_rdata = s_q.trig;
                IDX_KEY:  bus_rdata = s_q.key;
                IDX_PEND: bus_rdata = pend_vec;
                IDX_SYS:  bus_rdata = DATA_W'(s_q.idle);
                IDX_CNT:  bus_rdata = DATA_W'(count);
                IDX_STAT: bus_rdata = DATA_W'(sticky);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign unused_bits = ^{bus_addr[1:0], slot_data[IDX_CTRL][31:6],
                           slot_data[IDX_CTRL][1:0]};
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       wr_sel,
    input logic [31:0]      pend_vec,
    input logic [31:0]      load_eff,
    input logic             run,
    input logic             reload,
    input logic [CNT_W-1:0] count,
    input logic             wdt_rst_o,
    input logic             sticky,
    input logic             idle_gate_o
);
    logic [31:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= '0;
        else if (wdt_rst_o) hi_cnt <= hi_cnt + 1'b1;
        else                hi_cnt <= '0;
    end

    // R9: pulse never longer than RST_CYCLES
    a_r9_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (hi_cnt < RST_CYCLES));

    // R9: pulse exactly RST_CYCLES long when it ends
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (hi_cnt == RST_CYCLES));

    // R9: reset source flag is sticky and accompanies the pulse
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sticky));
    a_r9_sticky_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> sticky);

    // R5: load keeps its old value while its write is pending
    a_r5_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec[2] |-> $stable(load_eff));

    // R5: accepted load write raises its pending bit
    a_r5_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[1] && !pend_vec[2]) |=> pend_vec[2]);

    // R3: stopped counter holds unless reloaded
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(count));

    // R2: running counter moves by at most one step
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reload && count != '1) |=>
        (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    // R10: idle gating changes only on a system configuration write
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[5] |=> $stable(idle_gate_o));
endmodule

bind keyed_wdt kwdt_checker #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (wr_sel),
    .pend_vec   (pend_vec),
    .load_eff   (load_eff),
    .run        (run),
    .reload     (reload),
    .count      (count),
    .wdt_rst_o  (wdt_rst_o),
    .sticky     (sticky),
    .idle_gate_o(idle_gate_o)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC       = 4;

    localparam logic [4:0] A_CTRL = 5'h00, A_LOAD = 5'h04, A_TRIG = 5'h08,
                           A_KEY  = 5'h0C, A_PEND = 5'h10, A_SYS  = 5'h14,
                           A_CNT  = 5'h18, A_STAT = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;
    logic        idle_gate_o;

    int n_chk = 0;
    int n_fail = 0;

    keyed_wdt #(.ADDR_W(5), .CNT_W(32), .SYNC_TICKS(2), .RST_CYCLES(RSTC)) u_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .idle_gate_o(idle_gate_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            slow_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            slow_en = 1'b0;
        end
    endtask

    task automatic wrp(input logic [4:0] a, input logic [31:0] d);
        wr(a, d);
        tick(2);
    endtask

    task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", A_CTRL, 0);
        expect_reg("R1 load", A_LOAD, 0);
        expect_reg("R1 trig", A_TRIG, 0);
        expect_reg("R1 key", A_KEY, 0);
        expect_reg("R1 pend", A_PEND, 0);
        expect_reg("R1 sys", A_SYS, 0);
        expect_reg("R1 cnt", A_CNT, 0);
        expect_reg("R1 stat", A_STAT, 0);
        chk("R1 rst out", 32'(wdt_rst_o), 0);
        chk("R1 idle out", 32'(idle_gate_o), 0);
        tick(3);
        expect_reg("R1 cnt stopped", A_CNT, 0);
    endtask

    task automatic t_pending();
        wr(A_LOAD, 32'h100);
        expect_reg("R5 load pend bit2", A_PEND, 32'h4);
        expect_reg("R5 old load", A_LOAD, 0);
        wr(A_LOAD, 32'h200);
        tick(1);
        expect_reg("R5 still pend", A_PEND, 32'h4);
        expect_reg("R5 old load 2", A_LOAD, 0);
        tick(1);
        expect_reg("R5 pend clear", A_PEND, 0);
        expect_reg("R6 second write ignored", A_LOAD, 32'h100);
        wr(A_CTRL, 32'h0);
        expect_reg("R5 ctrl bit0", A_PEND, 32'h1);
        tick(2);
        wr(A_TRIG, 32'h5);
        expect_reg("R5 trig bit3", A_PEND, 32'h8);
        tick(2);
        expect_reg("R7 reload on new trig", A_CNT, 32'h100);
        wr(A_KEY, 32'h1234);
        expect_reg("R5 key bit4", A_PEND, 32'h10);
        tick(2);
        expect_reg("R5 key committed", A_KEY, 32'h1234);
    endtask

    task automatic t_start();
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h4444);
        expect_reg("R2 count at start", A_CNT, 32'h100);
        tick(5);
        expect_reg("R2 counts up", A_CNT, 32'h105);
    endtask

    task automatic t_trigger();
        wrp(A_TRIG, 32'h5);
        expect_reg("R7 same trig no reload", A_CNT, 32'h107);
        wrp(A_TRIG, 32'h6);
        expect_reg("R7 new trig reloads", A_CNT, 32'h100);
        tick(3);
        expect_reg("R7 runs after reload", A_CNT, 32'h103);
    endtask

    task automatic t_stop();
        wrp(A_KEY, 32'hAAAA);
        wrp(A_KEY, 32'h5555);
        expect_reg("R3 count at stop", A_CNT, 32'h107);
        tick(5);
        expect_reg("R3 holds when stopped", A_CNT, 32'h107);
    endtask

    task automatic t_partial();
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h1234);
        wrp(A_KEY, 32'h4444);
        tick(3);
        expect_reg("R4 broken start", A_CNT, 32'h107);
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h4444);
        wrp(A_KEY, 32'hAAAA);
        wrp(A_KEY, 32'h0);
        wrp(A_KEY, 32'h5555);
        tick(2);
        expect_reg("R4 broken stop keeps running", A_CNT, 32'h10F);
        wrp(A_KEY, 32'hAAAA);
        wrp(A_KEY, 32'h5555);
        expect_reg("R3 stop after partial", A_CNT, 32'h113);
    endtask

    task automatic t_prescale();
        wrp(A_CTRL, 32'h28);
        expect_reg("R8 ctrl readback", A_CTRL, 32'h28);
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h4444);
        tick(8);
        expect_reg("R8 two steps in 8 ticks", A_CNT, 32'h115);
        tick(3);
        expect_reg("R8 no step between", A_CNT, 32'h115);
        tick(1);
        expect_reg("R8 step on 4th tick", A_CNT, 32'h116);
        wrp(A_KEY, 32'hAAAA);
        wrp(A_KEY, 32'h5555);
        expect_reg("R8 step during stop", A_CNT, 32'h117);
        wrp(A_CTRL, 32'h0);
    endtask

    task automatic t_overflow();
        int n;
        wrp(A_LOAD, 32'hFFFF_FFFD);
        wrp(A_TRIG, 32'h7);
        expect_reg("R7 reload near top", A_CNT, 32'hFFFF_FFFD);
        wrp(A_KEY, 32'hBBBB);
        wrp(A_KEY, 32'h4444);
        tick(2);
        expect_reg("R9 at top", A_CNT, 32'hFFFF_FFFF);
        chk("R9 no pulse yet", 32'(wdt_rst_o), 0);
        expect_reg("R9 no flag yet", A_STAT, 0);
        tick(1);
        chk("R9 pulse starts", 32'(wdt_rst_o), 1);
        expect_reg("R9 reloads after wrap", A_CNT, 32'hFFFF_FFFD);
        n = 0;
        while (wdt_rst_o && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R9 pulse length", n, RSTC);
        expect_reg("R9 sticky flag", A_STAT, 1);
        tick(1);
        expect_reg("R9 keeps running", A_CNT, 32'hFFFF_FFFE);
        expect_reg("R9 flag stays", A_STAT, 1);
    endtask

    task automatic t_idle();
        wr(A_SYS, 32'h1);
        chk("R10 idle out set", 32'(idle_gate_o), 1);
        expect_reg("R10 sys readback", A_SYS, 1);
        expect_reg("R10 no pending", A_PEND, 0);
        wr(A_SYS, 32'h0);
        chk("R10 idle out clear", 32'(idle_gate_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_start();
        t_trigger();
        t_stop();
        t_partial();
        t_prescale();
        t_overflow();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule